// File: doc/BRIEF.md
# Bidirectional Raster Scan Sequencer

The sequencer steers a two-axis positioner, held as an X setpoint and a Y setpoint on two DAC channels, through a serpentine raster. On each line it sweeps forward and then retraces backward over the same path. After every programmed number of position steps it stops and takes a reading from each ADC enabled in a bitmap. It then pushes those readings, one word per ADC, into an output FIFO. Each word is tagged with its channel index and with the direction of the pass it was taken on.

A scan is started by raising `arm_i`. The block first reads back the current X and Y setpoints, so the raster begins wherever the positioner already sits. It then runs lines of forward and backward samples, with a vertical offset between lines. At the end it parks until `arm_i` is lowered. All configuration inputs are held stable while `arm_i` is high. Every DAC and ADC access is a level request that the attached converter completes with a one-cycle done pulse. The FIFO uses a valid/ready handshake, and the sequencer stalls while the sink is not ready.

ADC channels may be narrower than the widest one. Their raw buses are packed back to back, channel 0 at bit 0 and each next channel directly above the previous one. Each reading is sign-extended to the widest width before it leaves the block.

Top module: `serp_scan_seq`

## Requirements
- R1: After reset, no DAC request, no ADC request and no FIFO valid is asserted.
- R2: When `arm_i` is seen high in idle, both DAC channels are first accessed with `dac_wr_o`=0 (readback). The read values become the scan's start position, and no write precedes this readback.
- R3: In a forward pass each step writes X+dx and Y+dy (modulo 2^DAC_W). Each step waits for both DAC done pulses before the next one is issued, and exactly `steps_i` steps are made before every sample.
- R4: At each sample point, requests go only to ADC channel i for which `adc_used_i[i]`=1, while no DAC request is active. All selected channels complete before any FIFO word is offered.
- R5: Each sample yields one FIFO word per selected channel, in ascending channel order, with the channel index on `fifo_chan_o`. A word moves only in a cycle with valid and ready both high, and valid, data, channel and direction hold steady while the sink stalls.
- R6: `fifo_data_o` carries the channel's raw reading sign-extended from that channel's width to MAX_W.
- R7: After `samples_i` forward samples, the same number of backward samples follows. Each backward step writes X−dx and Y−dy, and backward words carry `fifo_bwd_o`=1 (forward words carry 0).
- R8: Between lines, after the backward pass, one move writes X+dxv and Y+dyv. No vertical move follows the last line.
- R9: After the last line the block issues no further requests or words while `arm_i` stays high. It returns to idle once `arm_i` is low, and a later rise starts a new scan with a fresh readback.
- R10: With `samples_i`=0 or `lines_i`=0, the scan does its readback and then parks, with no move, no ADC request and no FIFO word.
- R11: With `steps_i`=0, samples are taken with no step moves between them. Only the vertical moves occur.
- R12: With `adc_used_i`=0, no ADC request and no FIFO word is produced, and stepping proceeds through all samples and lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start a scan (level); low releases the parked state |
| steps_i | input | STEP_W | Steps between samples |
| samples_i | input | SAMP_W | Samples per pass |
| lines_i | input | SAMP_W | Number of lines |
| dx_i | input | DAC_W | X increment per step |
| dy_i | input | DAC_W | Y increment per step |
| dxv_i | input | DAC_W | X increment between lines |
| dyv_i | input | DAC_W | Y increment between lines |
| adc_used_i | input | N_ADC | Bit i enables ADC channel i |
| dac_wr_o | output | 1 | 1 = write setpoint, 0 = read back |
| dac_x_req_o | output | 1 | X DAC request |
| dac_x_wdata_o | output | DAC_W | X setpoint to write |
| dac_x_rdata_i | input | DAC_W | X setpoint read back |
| dac_x_done_i | input | 1 | X access complete (pulse) |
| dac_y_req_o | output | 1 | Y DAC request |
| dac_y_wdata_o | output | DAC_W | Y setpoint to write |
| dac_y_rdata_i | input | DAC_W | Y setpoint read back |
| dac_y_done_i | input | 1 | Y access complete (pulse) |
| adc_req_o | output | N_ADC | Conversion request per channel |
| adc_done_i | input | N_ADC | Conversion complete per channel (pulse) |
| adc_raw_i | input | RAW_W | Packed raw readings, channel 0 lowest |
| fifo_valid_o | output | 1 | Word offered |
| fifo_ready_i | input | 1 | Sink accepts word |
| fifo_data_o | output | MAX_W | Sign-extended reading |
| fifo_chan_o | output | CH_W | Channel index of the word |
| fifo_bwd_o | output | 1 | 1 = taken on a backward pass |

## Verification
The hardest situation to reach is a FIFO stall that lands in the middle of a multi-word sample on a backward pass of a later line. In that case the held channel index, the direction tag and the retraced position must all stay consistent while converter latencies differ per channel. The bench gets there by giving every DAC access and every conversion a random latency, and by dropping sink ready on about a quarter of cycles, across random raster shapes and ADC bitmaps. Directed runs cover the zero-sample, zero-line, zero-step and empty-bitmap shapes and negative increments that wrap the setpoints.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_STEP, S_MEAS, S_SEND, S_VERT, S_HOLD
  } scan_state_e;
endpackage

// File: rtl/scan_dac_pair.sv
module scan_dac_pair #(
  parameter int unsigned DW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          wr_i,
  input  logic [DW-1:0] tx_i,
  input  logic [DW-1:0] ty_i,
  output logic          x_req_o,
  output logic          y_req_o,
  output logic [DW-1:0] x_wdata_o,
  output logic [DW-1:0] y_wdata_o,
  input  logic [DW-1:0] x_rdata_i,
  input  logic [DW-1:0] y_rdata_i,
  input  logic          x_done_i,
  input  logic          y_done_i,
  output logic          done_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o
);
  logic x_ok, y_ok;

  assign x_req_o   = go_i & ~x_ok;
  assign y_req_o   = go_i & ~y_ok;
  assign x_wdata_o = tx_i;
  assign y_wdata_o = ty_i;
  assign done_o    = go_i & (x_ok | x_done_i) & (y_ok | y_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_ok <= 1'b0;
      y_ok <= 1'b0;
      x_o  <= '0;
      y_o  <= '0;
    end else begin
      if (done_o || !go_i) begin
        x_ok <= 1'b0;
        y_ok <= 1'b0;
      end else begin
        if (x_req_o && x_done_i) x_ok <= 1'b1;
        if (y_req_o && y_done_i) y_ok <= 1'b1;
      end
      if (x_req_o && x_done_i) x_o <= wr_i ? tx_i : x_rdata_i;
      if (y_req_o && y_done_i) y_o <= wr_i ? ty_i : y_rdata_i;
    end
  end

  // R3
  x_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_req_o && !x_done_i |=> x_req_o && $stable(x_wdata_o));
  // R3
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_req_o && !y_done_i |=> y_req_o && $stable(y_wdata_o));
endmodule

// File: rtl/scan_adc_gather.sv
module scan_adc_gather #(
  parameter int unsigned N     = 3,
  parameter int unsigned W [N] = '{24, 18, 12},
  parameter int unsigned MAX_W = 24,
  parameter int unsigned RAW_W = 54
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      go_i,
  input  logic [N-1:0]              mask_i,
  output logic [N-1:0]              req_o,
  input  logic [N-1:0]              done_i,
  input  logic [RAW_W-1:0]          raw_i,
  output logic                      all_o,
  output logic [N-1:0][MAX_W-1:0]   val_o
);
  function automatic int unsigned off_of(int unsigned idx);
    int unsigned s = 0;
    for (int unsigned i = 0; i < idx; i++) s += W[i];
    return s;
  endfunction

  logic [N-1:0] got, hit;

  assign req_o = {N{go_i}} & mask_i & ~got;
  assign hit   = req_o & done_i;
  assign all_o = go_i && (((got | hit) & mask_i) == mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              got <= '0;
    else if (!go_i || all_o)  got <= '0;
    else                      got <= got | hit;
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    localparam int unsigned WC  = W[g];
    localparam int unsigned OFF = off_of(g);
    logic [MAX_W-1:0] ext;
    if (WC < MAX_W) begin : g_sx
      assign ext = {{(MAX_W-WC){raw_i[OFF+WC-1]}}, raw_i[OFF +: WC]};
    end else begin : g_full
      assign ext = raw_i[OFF +: MAX_W];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     val_o[g] <= '0;
      else if (hit[g]) val_o[g] <= ext;
    end
  end
endmodule

// File: rtl/serp_scan_seq.sv
module serp_scan_seq
  import scan_pkg::*;
#(
  parameter int unsigned N_ADC         = 3,
  parameter int unsigned ADC_W [N_ADC] = '{24, 18, 12},
  parameter int unsigned MAX_W         = 24,
  parameter int unsigned RAW_W         = 54,
  parameter int unsigned DAC_W         = 20,
  parameter int unsigned STEP_W        = 16,
  parameter int unsigned SAMP_W        = 9,
  parameter int unsigned CH_W          = (N_ADC > 1) ? $clog2(N_ADC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic [SAMP_W-1:0] samples_i,
  input  logic [SAMP_W-1:0] lines_i,
  input  logic [DAC_W-1:0]  dx_i,
  input  logic [DAC_W-1:0]  dy_i,
  input  logic [DAC_W-1:0]  dxv_i,
  input  logic [DAC_W-1:0]  dyv_i,
  input  logic [N_ADC-1:0]  adc_used_i,
  output logic              dac_wr_o,
  output logic              dac_x_req_o,
  output logic [DAC_W-1:0]  dac_x_wdata_o,
  input  logic [DAC_W-1:0]  dac_x_rdata_i,
  input  logic              dac_x_done_i,
  output logic              dac_y_req_o,
  output logic [DAC_W-1:0]  dac_y_wdata_o,
  input  logic [DAC_W-1:0]  dac_y_rdata_i,
  input  logic              dac_y_done_i,
  output logic [N_ADC-1:0]  adc_req_o,
  input  logic [N_ADC-1:0]  adc_done_i,
  input  logic [RAW_W-1:0]  adc_raw_i,
  output logic              fifo_valid_o,
  input  logic              fifo_ready_i,
  output logic [MAX_W-1:0]  fifo_data_o,
  output logic [CH_W-1:0]   fifo_chan_o,
  output logic              fifo_bwd_o
);
  localparam logic [CH_W:0] NONE = (CH_W+1)'(N_ADC);

  function automatic logic [CH_W:0] find_from(input logic [N_ADC-1:0] m, input int from);
    logic [CH_W:0] r = NONE;
    for (int i = N_ADC - 1; i >= 0; i--)
      if (i >= from && m[i]) r = (CH_W+1)'(i);
    return r;
  endfunction

  scan_state_e              state, fin_st, pass_st;
  logic                     fwd, fin_fwd;
  logic [STEP_W-1:0]        step_cnt;
  logic [SAMP_W-1:0]        samp_cnt, line_cnt, fin_samp;
  logic [CH_W-1:0]          ch;
  logic [CH_W:0]            first_ch, next_ch;
  logic [DAC_W-1:0]         pos_x, pos_y, tx, ty;
  logic                     pos_go, pos_done, adc_all;
  logic [N_ADC-1:0][MAX_W-1:0] adc_val;

  assign pos_go   = (state == S_READ) || (state == S_STEP) || (state == S_VERT);
  assign dac_wr_o = (state != S_READ);
  assign pass_st  = (steps_i == '0) ? S_MEAS : S_STEP;
  assign first_ch = find_from(adc_used_i, 0);
  assign next_ch  = find_from(adc_used_i, int'(ch) + 1);

  always_comb begin
    if (state == S_VERT) begin
      tx = pos_x + dxv_i;
      ty = pos_y + dyv_i;
    end else if (fwd) begin
      tx = pos_x + dx_i;
      ty = pos_y + dy_i;
    end else begin
      tx = pos_x - dx_i;
      ty = pos_y - dy_i;
    end
  end

  // Where the scan goes once a sample is fully sent
  always_comb begin
    fin_st   = pass_st;
    fin_fwd  = fwd;
    fin_samp = samp_cnt + SAMP_W'(1);
    if (samp_cnt == samples_i - SAMP_W'(1)) begin
      fin_samp = '0;
      if (fwd)                                      fin_fwd = 1'b0;
      else if (line_cnt == lines_i - SAMP_W'(1))   fin_st  = S_HOLD;
      else                                          fin_st  = S_VERT;
    end
  end

  scan_dac_pair #(.DW(DAC_W)) u_dac (
    .clk_i, .rst_ni,
    .go_i      (pos_go),
    .wr_i      (dac_wr_o),
    .tx_i      (tx),
    .ty_i      (ty),
    .x_req_o   (dac_x_req_o),
    .y_req_o   (dac_y_req_o),
    .x_wdata_o (dac_x_wdata_o),
    .y_wdata_o (dac_y_wdata_o),
    .x_rdata_i (dac_x_rdata_i),
    .y_rdata_i (dac_y_rdata_i),
    .x_done_i  (dac_x_done_i),
    .y_done_i  (dac_y_done_i),
    .done_o    (pos_done),
    .x_o       (pos_x),
    .y_o       (pos_y)
  );

  scan_adc_gather #(.N(N_ADC), .W(ADC_W), .MAX_W(MAX_W), .RAW_W(RAW_W)) u_adc (
    .clk_i, .rst_ni,
    .go_i   (state == S_MEAS),
    .mask_i (adc_used_i),
    .req_o  (adc_req_o),
    .done_i (adc_done_i),
    .raw_i  (adc_raw_i),
    .all_o  (adc_all),
    .val_o  (adc_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      fwd      <= 1'b1;
      step_cnt <= '0;
      samp_cnt <= '0;
      line_cnt <= '0;
      ch       <= '0;
    end else begin
      case (state)
        S_IDLE: if (arm_i) state <= S_READ;
        S_READ: if (pos_done) begin
          fwd      <= 1'b1;
          step_cnt <= '0;
          samp_cnt <= '0;
          line_cnt <= '0;
          state    <= (samples_i == '0 || lines_i == '0) ? S_HOLD : pass_st;
        end
        S_STEP: if (pos_done) begin
          if (step_cnt == steps_i - STEP_W'(1)) begin
            step_cnt <= '0;
            state    <= S_MEAS;
          end else begin
            step_cnt <= step_cnt + STEP_W'(1);
          end
        end
        S_MEAS: if (adc_all) begin
          if (first_ch == NONE) begin
            state    <= fin_st;
            fwd      <= fin_fwd;
            samp_cnt <= fin_samp;
          end else begin
            ch    <= first_ch[CH_W-1:0];
            state <= S_SEND;
          end
        end
        S_SEND: if (fifo_ready_i) begin
          if (next_ch == NONE) begin
            state    <= fin_st;
            fwd      <= fin_fwd;
            samp_cnt <= fin_samp;
          end else begin
            ch <= next_ch[CH_W-1:0];
          end
        end
        S_VERT: if (pos_done) begin
          fwd      <= 1'b1;
          samp_cnt <= '0;
          line_cnt <= line_cnt + SAMP_W'(1);
          state    <= pass_st;
        end
        S_HOLD: if (!arm_i) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign fifo_valid_o = (state == S_SEND);
  assign fifo_data_o  = adc_val[ch];
  assign fifo_chan_o  = ch;
  assign fifo_bwd_o   = ~fwd;

  // R5
  fifo_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_valid_o && !fifo_ready_i |=> fifo_valid_o && $stable(fifo_data_o)
      && $stable(fifo_chan_o) && $stable(fifo_bwd_o));
  // R4
  adc_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|adc_req_o) |-> ((adc_req_o & ~adc_used_i) == '0) && !dac_x_req_o && !dac_y_req_o);
  // R9
  hold_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_HOLD && arm_i |=> state == S_HOLD && !fifo_valid_o && !dac_x_req_o);
  // R2
  read_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_IDLE && arm_i |=> dac_x_req_o && dac_y_req_o && !dac_wr_o);
endmodule

// File: tb/tb_serp_scan_seq.sv
module tb_serp_scan_seq;
  localparam int N = 3, MW = 24, RW = 54, DW = 20, SW = 16, PW = 9;
  localparam int AW [3] = '{24, 18, 12};

  logic clk = 0, rst_n = 0, arm = 0;
  logic [SW-1:0] steps = '0;
  logic [PW-1:0] samples = '0, lines = '0;
  logic [DW-1:0] dx = '0, dy = '0, dxv = '0, dyv = '0;
  logic [N-1:0]  used = '0;
  logic wr, x_req, y_req, x_done = 0, y_done = 0;
  logic [DW-1:0] x_wd, y_wd, x_rd = '0, y_rd = '0;
  logic [N-1:0] adc_req, adc_done = '0;
  logic [RW-1:0] adc_raw;
  logic f_valid, f_ready = 0, f_bwd;
  logic [MW-1:0] f_data;
  logic [1:0] f_chan;

  int n_chk = 0, n_bad = 0, xr = 0, yr = 0, early = 0, bad_req = 0;
  int kcnt [N] = '{0, 0, 0};
  int lat [N] = '{1, 0, 2};
  bit finished = 0;
  logic [DW-1:0] xw[$], yw[$];
  logic [MW+2:0] fq[$];

  always #5 clk = ~clk;

  serp_scan_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .steps_i(steps), .samples_i(samples),
    .lines_i(lines), .dx_i(dx), .dy_i(dy), .dxv_i(dxv), .dyv_i(dyv), .adc_used_i(used),
    .dac_wr_o(wr), .dac_x_req_o(x_req), .dac_x_wdata_o(x_wd), .dac_x_rdata_i(x_rd),
    .dac_x_done_i(x_done), .dac_y_req_o(y_req), .dac_y_wdata_o(y_wd),
    .dac_y_rdata_i(y_rd), .dac_y_done_i(y_done), .adc_req_o(adc_req),
    .adc_done_i(adc_done), .adc_raw_i(adc_raw), .fifo_valid_o(f_valid),
    .fifo_ready_i(f_ready), .fifo_data_o(f_data), .fifo_chan_o(f_chan), .fifo_bwd_o(f_bwd)
  );

  function automatic logic [31:0] hv(int c, int k);
    return (32'(k) * 32'h9E3779B1) ^ (32'(c + 1) * 32'h7F4A7C15) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [MW-1:0] sx(int c, logic [31:0] h);
    logic [MW-1:0] r = h[MW-1:0];
    for (int i = AW[c]; i < MW; i++) r[i] = h[AW[c]-1];
    return r;
  endfunction

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  // raw ADC bus, channels packed back to back from bit 0
  logic [31:0] hraw;
  int roff;
  always_comb begin
    adc_raw = '0;
    roff = 0;
    hraw = '0;
    for (int c = 0; c < N; c++) begin
      hraw = hv(c, kcnt[c]);
      for (int b = 0; b < AW[c]; b++) adc_raw[roff+b] = hraw[b];
      roff = roff + AW[c];
    end
  end

  initial forever begin
    @(negedge clk);
    if (x_req) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      if (wr) begin xw.push_back(x_wd); if (xr == 0) early++; end
      else begin xr++; if (xw.size() != 0) early++; end
      x_done = 1;
      @(negedge clk);
      x_done = 0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (y_req) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      if (wr) begin yw.push_back(y_wd); if (yr == 0) early++; end
      else begin yr++; if (yw.size() != 0) early++; end
      y_done = 1;
      @(negedge clk);
      y_done = 0;
    end
  end

  initial forever begin
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      if (adc_req[c] && !used[c]) bad_req++;
      if (adc_req[c] && (x_req || y_req)) bad_req++;
      if (adc_done[c]) begin
        adc_done[c] = 0;
        kcnt[c]++;
      end else if (adc_req[c]) begin
        if (lat[c] == 0) begin
          adc_done[c] = 1;
          lat[c] = $urandom_range(0, 3);
        end else lat[c]--;
      end
    end
  end

  logic [MW+2:0] held;
  bit stalled = 0;
  initial forever begin
    @(negedge clk);
    if (stalled) chk(f_valid && {f_bwd, f_chan, f_data} == held, "R5 word held during stall",
                     {f_valid, f_bwd, f_chan, f_data}, {1'b1, held});
    f_ready = ($urandom_range(0, 3) != 0);
    #1;
    stalled = f_valid && !f_ready;
    held = {f_bwd, f_chan, f_data};
    if (f_valid && f_ready) fq.push_back({f_bwd, f_chan, f_data});
  end

  task automatic run_scan(input string nm, input int k, input int s, input int l,
                          input logic [DW-1:0] ddx, input logic [DW-1:0] ddy,
                          input logic [DW-1:0] vx, input logic [DW-1:0] vy,
                          input logic [N-1:0] u);
    logic [DW-1:0] ex[$], ey[$];
    logic [MW+2:0] ef[$];
    logic [DW-1:0] cx, cy;
    int kc [N];
    int t;
    @(negedge clk);
    steps = SW'(k); samples = PW'(s); lines = PW'(l);
    dx = ddx; dy = ddy; dxv = vx; dyv = vy; used = u;
    x_rd = DW'($urandom); y_rd = DW'($urandom);
    xw.delete(); yw.delete(); fq.delete();
    xr = 0; yr = 0; early = 0; bad_req = 0;
    cx = x_rd; cy = y_rd;
    for (int c = 0; c < N; c++) kc[c] = kcnt[c];
    if (s > 0 && l > 0)
      for (int li = 0; li < l; li++) begin
        for (int p = 0; p < 2; p++)
          for (int si = 0; si < s; si++) begin
            for (int st = 0; st < k; st++) begin
              cx = (p == 1) ? cx - ddx : cx + ddx;
              cy = (p == 1) ? cy - ddy : cy + ddy;
              ex.push_back(cx); ey.push_back(cy);
            end
            for (int c = 0; c < N; c++)
              if (u[c]) begin
                ef.push_back({1'(p), 2'(c), sx(c, hv(c, kc[c]))});
                kc[c]++;
              end
          end
        if (li < l - 1) begin
          cx = cx + vx; cy = cy + vy;
          ex.push_back(cx); ey.push_back(cy);
        end
      end
    arm = 1;
    t = 0;
    while ((xw.size() < ex.size() || yw.size() < ey.size() || fq.size() < ef.size()
            || xr == 0 || yr == 0) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (30) @(negedge clk);
    chk(xr == 1 && yr == 1, $sformatf("%s R2 one readback per axis", nm), 64'(xr + yr), 2);
    chk(early == 0, $sformatf("%s R2 readback before any move", nm), 64'(early), 0);
    chk(xw.size() == ex.size(), $sformatf("%s R3 X move count", nm), 64'(xw.size()), 64'(ex.size()));
    chk(yw.size() == ey.size(), $sformatf("%s R3 Y move count", nm), 64'(yw.size()), 64'(ey.size()));
    for (int i = 0; i < ex.size() && i < xw.size(); i++)
      chk(xw[i] == ex[i], $sformatf("%s R3 R7 R8 X write %0d", nm, i), 64'(xw[i]), 64'(ex[i]));
    for (int i = 0; i < ey.size() && i < yw.size(); i++)
      chk(yw[i] == ey[i], $sformatf("%s R3 R7 R8 Y write %0d", nm, i), 64'(yw[i]), 64'(ey[i]));
    chk(fq.size() == ef.size(), $sformatf("%s R5 word count", nm), 64'(fq.size()), 64'(ef.size()));
    for (int i = 0; i < ef.size() && i < fq.size(); i++) begin
      chk(fq[i][MW-1:0] == ef[i][MW-1:0], $sformatf("%s R6 data word %0d", nm, i),
          64'(fq[i][MW-1:0]), 64'(ef[i][MW-1:0]));
      chk(fq[i][MW+1:MW] == ef[i][MW+1:MW], $sformatf("%s R5 channel word %0d", nm, i),
          64'(fq[i][MW+1:MW]), 64'(ef[i][MW+1:MW]));
      chk(fq[i][MW+2] == ef[i][MW+2], $sformatf("%s R7 direction word %0d", nm, i),
          64'(fq[i][MW+2]), 64'(ef[i][MW+2]));
    end
    chk(bad_req == 0, $sformatf("%s R4 ADC request outside mask or during move", nm), 64'(bad_req), 0);
    chk(!x_req && !y_req && !f_valid && adc_req == '0,
        $sformatf("%s R9 parked while armed", nm), {x_req, y_req, f_valid, adc_req}, 0);
    arm = 0;
    repeat (4) @(negedge clk);
    chk(!x_req && !y_req && !f_valid && xr == 1, $sformatf("%s R9 idle after arm low", nm),
        64'(xr), 1);
  endtask

  initial begin
    void'($urandom(32'd91357));
    repeat (3) @(negedge clk);
    chk(!x_req && !y_req && adc_req == '0 && !f_valid, "R1 reset outputs",
        {x_req, y_req, adc_req, f_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!x_req && !y_req && !f_valid, "R1 idle without arm", {x_req, y_req, f_valid}, 0);

    run_scan("basic", 2, 3, 2, 20'd5, -20'sd3, 20'd100, 20'd7, 3'b101);
    run_scan("R10 zero samples", 2, 0, 2, 20'd1, 20'd1, 20'd1, 20'd1, 3'b111);
    run_scan("R10 zero lines", 1, 2, 0, 20'd1, 20'd1, 20'd1, 20'd1, 3'b111);
    run_scan("R11 zero steps", 0, 2, 3, 20'd9, 20'd9, 20'd40, -20'sd40, 3'b010);
    run_scan("R12 empty bitmap", 1, 2, 2, 20'd3, 20'd4, 20'd11, 20'd12, 3'b000);
    run_scan("single point", 1, 1, 1, 20'd2, 20'd2, 20'd0, 20'd0, 3'b111);
    run_scan("wrap all channels", 3, 2, 2, 20'hFFFF0, 20'h00010, 20'hF0000, 20'h7FFFF, 3'b111);
    for (int r = 0; r < 8; r++)
      run_scan($sformatf("random %0d", r), $urandom_range(0, 3), $urandom_range(1, 4),
               $urandom_range(1, 3), DW'($urandom), DW'($urandom), DW'($urandom),
               DW'($urandom), N'($urandom));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R9 scan did not complete act=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule